// File: doc/BRIEF.md
# Low-Power DRAM Power-State Tracker

This block follows the power state of a low-power double data rate memory device by watching the device's control inputs: the active-low chip select, the clock enable, and the command/address bits sampled on the rising clock edge. While the device is awake it tracks which banks hold an open row, using activate and precharge commands. When clock enable drops, it picks the low-power state. If any row is open, the device freezes in active power-down. Otherwise the command on that same cycle decides the state: a no-operation gives idle power-down, a refresh-class code gives self-refresh, and a burst-terminate code gives deep power-down.

Deep power-down discards the memory contents. Raising clock enable does not leave it. Only the synchronous reset brings the tracker back, and a status output asks for that reset. While the device is in any low-power state, no command is accepted. A command that arrives in a low-power state, other than the wake-up condition, raises an error pulse.

Top module: `lpd_power_tracker`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) puts the tracker in state code 0 (idle). After that edge, `reset_required` is low, `illegal_cmd` is low and `open_banks` is all zeros.
- R2: While `cs_n` is high, every cycle is treated as a no-operation, whatever is on `ca`. No command is accepted, and a clock-enable fall in that cycle selects idle power-down.
- R3: An accepted activate (`ca[1:0]` = 2'b10, i.e. CA0 low and CA1 high) opens the bank given by {`ca[7]`,`ca[8]`,`ca[9]`} as bank-address bits 2..0; with `NUM_BANKS`=4 the top bit is dropped. An accepted precharge-one (`ca[2:0]`=3'b011, `ca[3]`=1, `ca[4]`=0) closes that bank. An accepted precharge-all (same but `ca[4]`=1) closes every bank. While awake, `pwr_state` is 1 (active) if any bank is open and 0 (idle) otherwise.
- R4: `cmd_accept` is high in the same cycle exactly when the tracker is awake, `cke` is high, `cs_n` is low and `ca[2:0]` is not 3'b111.
- R5: When `cke` was high at the previous edge and is low now, and any bank is open, the next state is active power-down (code 2), whatever the command. The open banks are held. A later edge with `cke` high returns to active (code 1) with the same banks open.
- R6: A clock-enable fall with no bank open and a no-operation command (`cs_n` high or `ca[2:0]`=3'b111) enters idle power-down (code 3). An edge with `cke` high returns to idle (code 0).
- R7: A clock-enable fall with no bank open and a refresh-class command (`ca[2:0]`=3'b100, CA0 and CA1 low, CA2 high) enters self-refresh (code 4). The state holds while `cke` stays low, and an edge with `cke` high returns to idle (code 0).
- R8: A clock-enable fall with no bank open and a burst-terminate command (`ca[2:0]`=3'b011, `ca[3]`=0) enters deep power-down (code 5) with `reset_required` high. Raising `cke` does not leave this state; only R1's reset does.
- R9: One cycle after an edge at which a non-no-operation command is present, `illegal_cmd` is high for one cycle if that edge was either in active power-down, idle power-down or self-refresh with `cke` low, or in deep power-down at any `cke` level. Such a command changes neither the state nor `open_banks`.
- R10: A clock-enable fall with no bank open and any other command (activate, read/write, precharge, mode-register access) enters idle power-down and raises `illegal_cmd` one cycle later.
- R11: The reset of R1 works from every state, deep power-down included, and clears `reset_required`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| cke | input | 1 | Clock enable |
| ca | input | 10 | Command/address bits of the rising edge; ca[0] is CA0 |
| cmd_accept | output | 1 | Command on the inputs is executed this cycle |
| open_banks | output | NUM_BANKS | One bit per bank, set while that bank has an open row |
| pwr_state | output | 3 | 0 idle, 1 active, 2 active power-down, 3 idle power-down, 4 self-refresh, 5 deep power-down |
| reset_required | output | 1 | High while in deep power-down |
| illegal_cmd | output | 1 | One-cycle pulse for a command refused in a low-power state |

## Verification
The hardest case to reach is active power-down with a specific set of banks frozen. Getting there takes accepted activates first, then a clock-enable fall carrying a command that would otherwise pick a different state. The test then tries to disturb the frozen banks with a precharge-all while asleep and checks that they come back unchanged after wake-up. Deep power-down is reached the same way from idle. The test raises clock enable and issues an activate there, expecting no exit and no open bank until the reset is applied.

// File: rtl/lpd_pkg.sv
`timescale 1ns/1ps
package lpd_pkg;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RW, CMD_PRE_ONE, CMD_PRE_ALL, CMD_BST, CMD_REF, CMD_MR
  } cmd_e;

  typedef enum logic [2:0] {
    PS_AWAKE, PS_APD, PS_IPD, PS_SREF, PS_DPD
  } pstate_e;

  localparam logic [2:0] CODE_IDLE = 3'd0;
  localparam logic [2:0] CODE_ACT  = 3'd1;
  localparam logic [2:0] CODE_APD  = 3'd2;
  localparam logic [2:0] CODE_IPD  = 3'd3;
  localparam logic [2:0] CODE_SREF = 3'd4;
  localparam logic [2:0] CODE_DPD  = 3'd5;

endpackage

// File: rtl/lpd_cmd_decode.sv
`timescale 1ns/1ps
module lpd_cmd_decode
  import lpd_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic            cs_n,
  input  logic [9:0]      ca,
  output cmd_e            cmd,
  output logic [BA_W-1:0] bank
);
  logic [2:0] ba_full;

  // bank address: CA7 carries bit 2, CA9 carries bit 0
  assign ba_full = {ca[7], ca[8], ca[9]};
  assign bank    = ba_full[BA_W-1:0];

  always_comb begin
    cmd = CMD_NOP;
    if (!cs_n) begin
      unique case (ca[2:0])
        3'b111:          cmd = CMD_NOP;
        3'b011:          cmd = !ca[3] ? CMD_BST : (ca[4] ? CMD_PRE_ALL : CMD_PRE_ONE);
        3'b101, 3'b001:  cmd = CMD_RW;
        3'b110, 3'b010:  cmd = CMD_ACT;
        3'b100:          cmd = CMD_REF;
        default:         cmd = CMD_MR;
      endcase
    end
  end
endmodule

// File: rtl/lpd_bank_tracker.sv
`timescale 1ns/1ps
module lpd_bank_tracker
  import lpd_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 accept,
  input  cmd_e                 cmd,
  input  logic [BA_W-1:0]      bank,
  output logic [NUM_BANKS-1:0] open_banks
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (bank == BA_W'(b));
    always_ff @(posedge clk) begin
      if (rst)
        open_banks[b] <= 1'b0;
      else if (accept && (cmd == CMD_PRE_ALL || (cmd == CMD_PRE_ONE && hit)))
        open_banks[b] <= 1'b0;
      else if (accept && cmd == CMD_ACT && hit)
        open_banks[b] <= 1'b1;
    end
  end

  assert_banks_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(open_banks));

  assert_activate_opens_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && cmd == CMD_ACT) |=> open_banks[$past(bank)]);
endmodule

// File: rtl/lpd_pwr_fsm.sv
`timescale 1ns/1ps
module lpd_pwr_fsm
  import lpd_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    cke,
  input  cmd_e    cmd,
  input  logic    any_open,
  output pstate_e state,
  output logic    accept,
  output logic    illegal_q
);
  logic    cke_q;
  logic    cke_fall;
  logic    bad_cmd;
  pstate_e state_d;

  assign cke_fall = cke_q && !cke;
  assign accept   = (state == PS_AWAKE) && cke && (cmd != CMD_NOP);

  always_comb begin
    state_d = state;
    bad_cmd = 1'b0;
    unique case (state)
      PS_AWAKE: if (cke_fall) begin
        if (any_open) state_d = PS_APD;
        else begin
          unique case (cmd)
            CMD_NOP: state_d = PS_IPD;
            CMD_REF: state_d = PS_SREF;
            CMD_BST: state_d = PS_DPD;
            default: begin
              state_d = PS_IPD;
              bad_cmd = 1'b1;
            end
          endcase
        end
      end
      PS_APD, PS_IPD, PS_SREF: begin
        if (cke) state_d = PS_AWAKE;
        else     bad_cmd = (cmd != CMD_NOP);
      end
      PS_DPD:  bad_cmd = (cmd != CMD_NOP);
      default: state_d = PS_AWAKE;
    endcase
  end

  always_ff @(posedge clk) begin
    cke_q <= cke;
    if (rst) begin
      state     <= PS_AWAKE;
      illegal_q <= 1'b0;
    end else begin
      state     <= state_d;
      illegal_q <= bad_cmd;
    end
  end

  assert_dpd_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    state == PS_DPD |=> state == PS_DPD);

  assert_sref_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (state == PS_SREF && !cke) |=> state == PS_SREF);

  assert_apd_entry_R5: assert property (@(posedge clk) disable iff (rst)
    (state == PS_AWAKE && cke_q && !cke && any_open) |=> state == PS_APD);

  assert_reset_idle_R11: assert property (@(posedge clk)
    rst |=> (state == PS_AWAKE && !illegal_q));

  assert_illegal_origin_R9: assert property (@(posedge clk) disable iff (rst)
    illegal_q |-> $past(state != PS_AWAKE || !cke));
endmodule

// File: rtl/lpd_power_tracker.sv
`timescale 1ns/1ps
module lpd_power_tracker
  import lpd_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_n,
  input  logic                 cke,
  input  logic [9:0]           ca,
  output logic                 cmd_accept,
  output logic [NUM_BANKS-1:0] open_banks,
  output logic [2:0]           pwr_state,
  output logic                 reset_required,
  output logic                 illegal_cmd
);
  cmd_e            cmd;
  logic [BA_W-1:0] bank;
  pstate_e         state;
  logic            any_open;

  lpd_cmd_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .cs_n(cs_n), .ca(ca), .cmd(cmd), .bank(bank)
  );

  lpd_bank_tracker #(.NUM_BANKS(NUM_BANKS)) u_banks (
    .clk(clk), .rst(rst), .accept(cmd_accept), .cmd(cmd), .bank(bank),
    .open_banks(open_banks)
  );

  assign any_open = |open_banks;

  lpd_pwr_fsm u_fsm (
    .clk(clk), .rst(rst), .cke(cke), .cmd(cmd), .any_open(any_open),
    .state(state), .accept(cmd_accept), .illegal_q(illegal_cmd)
  );

  always_comb begin
    unique case (state)
      PS_AWAKE: pwr_state = any_open ? CODE_ACT : CODE_IDLE;
      PS_APD:   pwr_state = CODE_APD;
      PS_IPD:   pwr_state = CODE_IPD;
      PS_SREF:  pwr_state = CODE_SREF;
      PS_DPD:   pwr_state = CODE_DPD;
      default:  pwr_state = CODE_IDLE;
    endcase
  end

  assign reset_required = (state == PS_DPD);

  assert_no_accept_asleep_R4: assert property (@(posedge clk) disable iff (rst)
    cmd_accept |-> (pwr_state == CODE_IDLE || pwr_state == CODE_ACT));
endmodule

// File: tb/lpd_power_tracker_test.sv
`timescale 1ns/1ps
module lpd_power_tracker_test;
  localparam int NB = 8;
  localparam logic [9:0] NOP   = 10'b0000000111;
  localparam logic [9:0] BST   = 10'b0000000011;
  localparam logic [9:0] REF   = 10'b0000000100;
  localparam logic [9:0] READ  = 10'b0000000101;
  localparam logic [9:0] PREA  = 10'b0000011011;

  logic clk = 1'b0;
  logic rst, cs_n, cke;
  logic [9:0] ca;
  logic cmd_accept, reset_required, illegal_cmd;
  logic [NB-1:0] open_banks;
  logic [2:0] pwr_state;
  int checks = 0;
  int fails = 0;

  lpd_power_tracker #(.NUM_BANKS(NB)) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .cke(cke), .ca(ca),
    .cmd_accept(cmd_accept), .open_banks(open_banks), .pwr_state(pwr_state),
    .reset_required(reset_required), .illegal_cmd(illegal_cmd)
  );

  always #2.5 clk = ~clk;

  function automatic logic [9:0] f_act(input logic [2:0] b);
    logic [9:0] v = 10'b0000000010;
    v[7] = b[2]; v[8] = b[1]; v[9] = b[0];
    return v;
  endfunction

  function automatic logic [9:0] f_pre(input logic [2:0] b);
    logic [9:0] v = 10'b0000001011;
    v[7] = b[2]; v[8] = b[1]; v[9] = b[0];
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic k, input logic [9:0] a);
    cs_n = c; cke = k; ca = a;
    @(posedge clk); #1;
  endtask

  task automatic peek_step(input logic c, input logic k, input logic [9:0] a,
                           input logic exp, input string req);
    cs_n = c; cke = k; ca = a;
    #1 chk(req, cmd_accept, exp);
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(1'b1, 1'b0, NOP);
    step(1'b1, 1'b0, NOP);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 state", pwr_state, 3'd0);
    chk("R1 rstreq", reset_required, 1'b0);
    chk("R1 illegal", illegal_cmd, 1'b0);
    chk("R1 banks", open_banks, '0);
  endtask

  task automatic t_banks();
    peek_step(1'b0, 1'b1, f_act(3'd2), 1'b1, "R4 activate accepted");
    chk("R3 open bank2", open_banks, 8'h04);
    chk("R3 active code", pwr_state, 3'd1);
    peek_step(1'b0, 1'b1, f_act(3'd5), 1'b1, "R4 activate accepted");
    chk("R3 open bank5", open_banks, 8'h24);
    peek_step(1'b0, 1'b1, f_pre(3'd2), 1'b1, "R4 precharge accepted");
    chk("R3 close bank2", open_banks, 8'h20);
    peek_step(1'b0, 1'b1, NOP, 1'b0, "R4 nop not accepted");
    step(1'b0, 1'b1, PREA);
    chk("R3 precharge all", open_banks, 8'h00);
    chk("R3 idle code", pwr_state, 3'd0);
  endtask

  task automatic t_cs_high();
    peek_step(1'b1, 1'b1, f_act(3'd1), 1'b0, "R2 deselected not accepted");
    chk("R2 no bank opened", open_banks, 8'h00);
    step(1'b1, 1'b0, BST);
    chk("R2 deselect fall gives idle pd", pwr_state, 3'd3);
    step(1'b0, 1'b1, NOP);
    chk("R2 wake", pwr_state, 3'd0);
  endtask

  task automatic t_idle_pd();
    step(1'b0, 1'b1, NOP);
    step(1'b0, 1'b0, NOP);
    chk("R6 idle pd", pwr_state, 3'd3);
    step(1'b0, 1'b0, NOP);
    chk("R6 stays", pwr_state, 3'd3);
    step(1'b0, 1'b1, NOP);
    chk("R6 exit idle", pwr_state, 3'd0);
  endtask

  task automatic t_self_refresh();
    step(1'b0, 1'b1, NOP);
    step(1'b0, 1'b0, REF);
    chk("R7 self refresh", pwr_state, 3'd4);
    step(1'b0, 1'b0, NOP);
    step(1'b0, 1'b0, NOP);
    chk("R7 holds", pwr_state, 3'd4);
    step(1'b0, 1'b1, NOP);
    chk("R7 exit idle", pwr_state, 3'd0);
  endtask

  task automatic t_active_pd();
    step(1'b0, 1'b1, f_act(3'd5));
    step(1'b0, 1'b0, READ);
    chk("R5 active pd", pwr_state, 3'd2);
    chk("R5 no error", illegal_cmd, 1'b0);
    chk("R5 banks held", open_banks, 8'h20);
    peek_step(1'b0, 1'b0, PREA, 1'b0, "R4 asleep not accepted");
    chk("R9 illegal flagged", illegal_cmd, 1'b1);
    chk("R9 banks unchanged", open_banks, 8'h20);
    chk("R9 state unchanged", pwr_state, 3'd2);
    step(1'b0, 1'b1, NOP);
    chk("R5 exit active", pwr_state, 3'd1);
    chk("R5 banks after wake", open_banks, 8'h20);
    chk("R9 pulse ends", illegal_cmd, 1'b0);
    step(1'b0, 1'b1, PREA);
    chk("R3 closed", pwr_state, 3'd0);
  endtask

  task automatic t_bad_selector();
    step(1'b0, 1'b1, NOP);
    step(1'b0, 1'b0, f_act(3'd1));
    chk("R10 idle pd", pwr_state, 3'd3);
    chk("R10 illegal", illegal_cmd, 1'b1);
    chk("R10 no bank", open_banks, 8'h00);
    step(1'b0, 1'b0, f_act(3'd3));
    chk("R9 illegal in idle pd", illegal_cmd, 1'b1);
    step(1'b0, 1'b1, NOP);
    chk("R9 activate ignored", open_banks, 8'h00);
    chk("R6 wake", pwr_state, 3'd0);
  endtask

  task automatic t_deep_pd();
    step(1'b0, 1'b1, NOP);
    step(1'b0, 1'b0, BST);
    chk("R8 deep pd", pwr_state, 3'd5);
    chk("R8 reset required", reset_required, 1'b1);
    step(1'b0, 1'b1, NOP);
    chk("R8 cke high no exit", pwr_state, 3'd5);
    peek_step(1'b0, 1'b1, f_act(3'd4), 1'b0, "R4 deep not accepted");
    chk("R9 illegal in deep", illegal_cmd, 1'b1);
    chk("R9 no bank in deep", open_banks, 8'h00);
    chk("R8 still deep", pwr_state, 3'd5);
    do_reset();
    chk("R11 idle after reset", pwr_state, 3'd0);
    chk("R11 flag cleared", reset_required, 1'b0);
  endtask

  bit done = 1'b0;

  initial begin
    rst = 1'b1; cs_n = 1'b1; cke = 1'b0; ca = NOP;
    t_reset();
    t_banks();
    t_cs_high();
    t_idle_pd();
    t_self_refresh();
    t_active_pd();
    t_bad_selector();
    t_deep_pd();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule